// File: doc/BRIEF.md
# Stereo Voice Sample Buffer with Programmable Status Flags

This block sits between a host that writes packed voice samples and a consumer that drains them one 4-bit nibble per sample tick. It holds two independent nibble buffers, left and right. Only the left one is used in record and mono-playback modes. Both are used in stereo playback. The usable capacity of each buffer is chosen by configuration: 64, 128 or 256 nibbles, which is 256, 512 or 1024 bits.

Three status outputs report empty, more-than-half-full and full. A configuration bit per flag flips its active level. In stereo mode a channel-select input chooses whether the flags describe the right or the left buffer.

A small sequencer has three states: `ST_IDLE`, `ST_ARMED` and `ST_RUN`. Its transitions are:
- **start-play** (`ST_IDLE`→`ST_ARMED`): `start` in a playback mode.
- **start-record** (`ST_IDLE`→`ST_RUN`): `start` in record mode.
- **threshold** (`ST_ARMED`→`ST_RUN`): every used buffer has passed half full. This transition emits a one-cycle `play_start` pulse.
- **halt** (any→`ST_IDLE`): `stop` or `cfg_load`.

Consumer reads are honoured only in `ST_RUN`.

Top module: `vfifo_stereo`

## Requirements
- R1: `cfg_size` selects the capacity of each buffer: 0 gives 64 nibbles, 1 gives 128 nibbles, and 2 or 3 give 256 nibbles.
- R2: An accepted write stores nibbles starting with the least significant one, `wr_data[3:0]`. With `wr_wide`=0 it stores two nibbles and with `wr_wide`=1 it stores four. The consumer receives them in that order.
- R3: A write is accepted, and `wr_ok` is high in that cycle, only when the target buffer has free room for all of its nibbles. A write to a full buffer is always refused and changes nothing.
- R4: The raw empty flag is true when the selected buffer holds zero nibbles.
- R5: The raw mid flag is true when the selected buffer holds more than half of its capacity.
- R6: The raw full flag is true when the selected buffer holds exactly its capacity.
- R7: Each output flag equals its raw flag XOR a bit of `cfg_inv`: bit 0 for empty, bit 1 for mid, bit 2 for full.
- R8: `cfg_mode` encodes 0 as record, 1 as mono playback, 2 as stereo playback and 3 as mono playback. In stereo mode, `ch_sel`=1 routes the right buffer's flags to the outputs, `ch_sel`=0 routes the left buffer's, and `wr_right`=1 writes the right buffer. In other modes `ch_sel` and `wr_right` are ignored, writes go to the left buffer, and `rd_data_r` is 0.
- R9: `rd_data_l` and `rd_data_r` show the head nibble of their buffer, or 0 when it is empty. A read of an empty buffer does not move it.
- R10: In a playback mode, `start` enters `ST_ARMED`. Reads are ignored there. The state moves to `ST_RUN` one cycle after the left buffer (and, in stereo, also the right) first exceeds half full, and `play_start` is high for exactly the first `ST_RUN` cycle. In record mode, `start` enters `ST_RUN` directly without a pulse.
- R11: Reset or `cfg_load` empties both buffers and returns the sequencer to `ST_IDLE`. After reset the configuration is 256 nibbles, mono playback and no inversion.
- R12: `stop` returns the sequencer to `ST_IDLE`. Reads are then ignored and stored data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load configuration and clear both buffers |
| cfg_size | input | 2 | Capacity select |
| cfg_mode | input | 2 | Operating mode |
| cfg_inv | input | 3 | Flag polarity inversion bits |
| ch_sel | input | 1 | Flag channel select (stereo only) |
| start | input | 1 | Start request |
| stop | input | 1 | Stop request |
| wr_en | input | 1 | Host write strobe |
| wr_wide | input | 1 | 1: four-nibble write, 0: two-nibble write |
| wr_right | input | 1 | Write targets the right buffer (stereo only) |
| wr_data | input | 16 | Packed write data |
| wr_ok | output | 1 | Write accepted this cycle |
| rd_en | input | 1 | Consumer sample tick |
| rd_data_l | output | 4 | Left head nibble |
| rd_data_r | output | 4 | Right head nibble |
| flag_empty | output | 1 | Empty flag after polarity |
| flag_mid | output | 1 | Over-half flag after polarity |
| flag_full | output | 1 | Full flag after polarity |
| play_start | output | 1 | One-cycle start-of-playback pulse |
| running | output | 1 | Sequencer is in `ST_RUN` |

## Verification
A wrong occupancy count shows at the flag outputs one cycle after the write or read that caused it. The capacity sweeps compare all three flags after every single write, so a threshold error is caught at the exact nibble count where it first appears. A wrong read pointer shows on the next read as a nibble that differs from the order the bench predicts from the written words. A sequencer stuck in or skipping `ST_ARMED` shows as `running` or `play_start` disagreeing in the single cycle after the threshold-crossing write.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_REC    = 2'd0,
        MODE_MONO   = 2'd1,
        MODE_STEREO = 2'd2,
        MODE_MONO2  = 2'd3
    } mode_t;

    localparam int NIB_W = 4;
endpackage

// File: rtl/vfifo_buf.sv
module vfifo_buf #(
    parameter int DEPTH    = 256,
    parameter int WORD_NIB = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int KW = $clog2(WORD_NIB + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [CW-1:0]         cap,
    input  logic                  wr_en,
    input  logic [KW-1:0]         wr_k,
    input  logic [WORD_NIB*4-1:0] wr_word,
    output logic                  wr_ok,
    input  logic                  rd_en,
    output logic [3:0]            head,
    output logic [CW-1:0]         cnt
);
    logic [3:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr, mask;
    logic [CW-1:0] free, capm1;
    logic          pop;

    assign capm1 = cap - CW'(1);
    assign mask  = capm1[AW-1:0];
    assign free  = cap - cnt;
    assign wr_ok = wr_en && !clr && (CW'(wr_k) <= free);
    assign pop   = rd_en && !clr && (cnt != '0);
    assign head  = (cnt == '0) ? 4'h0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            for (int i = 0; i < WORD_NIB; i++) begin
                if (i < int'(wr_k)) begin
                    mem[(wptr + AW'(i)) & mask] <= wr_word[4*i +: 4];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr + AW'(wr_k)) & mask;
            if (pop)   rptr <= (rptr + AW'(1)) & mask;
            cnt <= cnt + (wr_ok ? CW'(wr_k) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    // R3: occupancy never exceeds the configured capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt <= cap);
    // R9: an empty buffer keeps its read position
    a_r9_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !clr) |=> rptr == $past(rptr));
    // R11: a configuration load empties the buffer
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/vfifo_flags.sv
module vfifo_flags #(
    parameter int CW = 9
) (
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] cnt_l,
    input  logic [CW-1:0] cnt_r,
    input  logic          stereo,
    input  logic          ch_sel,
    input  logic [2:0]    inv,
    output logic [1:0]    mid_raw,
    output logic          flag_empty,
    output logic          flag_mid,
    output logic          flag_full
);
    logic [CW-1:0] cnts [2];
    logic [1:0]    empty_raw, full_raw;
    logic          sel;

    assign cnts[0] = cnt_l;
    assign cnts[1] = cnt_r;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        assign empty_raw[ch] = (cnts[ch] == '0);
        assign mid_raw[ch]   = (cnts[ch] > (cap >> 1));
        assign full_raw[ch]  = (cnts[ch] == cap);
    end

    assign sel        = stereo && ch_sel;
    assign flag_empty = empty_raw[sel] ^ inv[0];
    assign flag_mid   = mid_raw[sel]   ^ inv[1];
    assign flag_full  = full_raw[sel]  ^ inv[2];
endmodule

// File: rtl/vfifo_seq.sv
module vfifo_seq
    import vfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  start,
    input  logic  stop,
    input  mode_t mode,
    input  logic  mid_l,
    input  logic  mid_r,
    output logic  running,
    output logic  play_start
);
    seq_state_t state, nxt;
    logic       stereo, filled;

    assign stereo  = (mode == MODE_STEREO);
    assign filled  = mid_l && (!stereo || mid_r);
    assign running = (state == ST_RUN);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (mode == MODE_REC) ? ST_RUN : ST_ARMED;
            ST_ARMED: if (filled) nxt = ST_RUN;
            ST_RUN:   nxt = ST_RUN;
            default:  nxt = ST_IDLE;
        endcase
        if (clr || stop) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) play_start <= 1'b0;
        else        play_start <= (state == ST_ARMED) && (nxt == ST_RUN);
    end

    // R10: the pulse only follows the armed state
    a_r10_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
        play_start |-> $past(state) == ST_ARMED);
    // R10: the pulse lasts one cycle
    a_r10_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        play_start |=> !play_start);
    // R10: no run before the threshold
    a_r10_arm_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !mid_l) |=> state != ST_RUN);
    // R12: stop halts the sequencer
    a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> state == ST_IDLE);
endmodule

// File: rtl/vfifo_stereo.sv
module vfifo_stereo
    import vfifo_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int WORD_NIB = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int KW = $clog2(WORD_NIB + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_load,
    input  logic [1:0]            cfg_size,
    input  logic [1:0]            cfg_mode,
    input  logic [2:0]            cfg_inv,
    input  logic                  ch_sel,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  wr_en,
    input  logic                  wr_wide,
    input  logic                  wr_right,
    input  logic [WORD_NIB*4-1:0] wr_data,
    output logic                  wr_ok,
    input  logic                  rd_en,
    output logic [3:0]            rd_data_l,
    output logic [3:0]            rd_data_r,
    output logic                  flag_empty,
    output logic                  flag_mid,
    output logic                  flag_full,
    output logic                  play_start,
    output logic                  running
);
    logic [1:0]    size_q;
    mode_t         mode_q;
    logic [2:0]    inv_q;
    logic [CW-1:0] cap;
    logic          stereo;
    logic [KW-1:0] wr_k;
    logic [1:0]    ch_wr, ch_ok, ch_rd, mid_raw;
    logic [3:0]    ch_head [2];
    logic [CW-1:0] ch_cnt  [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= 2'd2;
            mode_q <= MODE_MONO;
            inv_q  <= 3'b000;
        end else if (cfg_load) begin
            size_q <= cfg_size;
            mode_q <= mode_t'(cfg_mode);
            inv_q  <= cfg_inv;
        end
    end

    always_comb begin
        unique case (size_q)
            2'd0:    cap = CW'(DEPTH / 4);
            2'd1:    cap = CW'(DEPTH / 2);
            default: cap = CW'(DEPTH);
        endcase
    end

    assign stereo   = (mode_q == MODE_STEREO);
    assign wr_k     = wr_wide ? KW'(WORD_NIB) : KW'(WORD_NIB / 2);
    assign ch_wr[0] = wr_en && !(stereo && wr_right);
    assign ch_wr[1] = wr_en && stereo && wr_right;
    assign ch_rd[0] = rd_en && running;
    assign ch_rd[1] = rd_en && running && stereo;

    for (genvar ch = 0; ch < 2; ch++) begin : g_buf
        vfifo_buf #(.DEPTH(DEPTH), .WORD_NIB(WORD_NIB)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cfg_load),
            .cap     (cap),
            .wr_en   (ch_wr[ch]),
            .wr_k    (wr_k),
            .wr_word (wr_data),
            .wr_ok   (ch_ok[ch]),
            .rd_en   (ch_rd[ch]),
            .head    (ch_head[ch]),
            .cnt     (ch_cnt[ch])
        );
    end

    assign wr_ok     = |ch_ok;
    assign rd_data_l = ch_head[0];
    assign rd_data_r = stereo ? ch_head[1] : 4'h0;

    vfifo_flags #(.CW(CW)) u_flags (
        .cap        (cap),
        .cnt_l      (ch_cnt[0]),
        .cnt_r      (ch_cnt[1]),
        .stereo     (stereo),
        .ch_sel     (ch_sel),
        .inv        (inv_q),
        .mid_raw    (mid_raw),
        .flag_empty (flag_empty),
        .flag_mid   (flag_mid),
        .flag_full  (flag_full)
    );

    vfifo_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cfg_load),
        .start      (start),
        .stop       (stop),
        .mode       (mode_q),
        .mid_l      (mid_raw[0]),
        .mid_r      (mid_raw[1]),
        .running    (running),
        .play_start (play_start)
    );

    // R3: a full target refuses the write
    a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr[0] && ch_cnt[0] == cap) |-> !ch_ok[0]);
    // R8: the right buffer stays unused outside stereo
    a_r8_right_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!stereo && !$past(stereo)) |-> ch_cnt[1] == '0);
    // R7: empty selected buffer shows empty at the configured level
    a_r7_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stereo && ch_sel) && ch_cnt[0] == '0) |-> flag_empty == !inv_q[0]);
    // R6: empty and full never coincide on the raw level
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_empty ^ inv_q[0], flag_full ^ inv_q[2]}));
endmodule

// File: tb/vfifo_stereo_tb.sv
module vfifo_stereo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 0, ch_sel = 0, start = 0, stop = 0;
    logic [1:0]  cfg_size = 0, cfg_mode = 0;
    logic [2:0]  cfg_inv = 0;
    logic        wr_en = 0, wr_wide = 0, wr_right = 0, rd_en = 0;
    logic [15:0] wr_data = 0;
    logic        wr_ok, flag_empty, flag_mid, flag_full, play_start, running;
    logic [3:0]  rd_data_l, rd_data_r;

    int n_chk = 0, n_err = 0, cyc = 0;
    int m_cap = 256;
    bit m_stereo = 0, m_run = 0;
    logic [2:0] m_inv = 0;
    logic [3:0] q_l[$];
    logic [3:0] q_r[$];

    always #2 clk = ~clk;

    vfifo_stereo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_size(cfg_size),
        .cfg_mode(cfg_mode), .cfg_inv(cfg_inv), .ch_sel(ch_sel), .start(start),
        .stop(stop), .wr_en(wr_en), .wr_wide(wr_wide), .wr_right(wr_right),
        .wr_data(wr_data), .wr_ok(wr_ok), .rd_en(rd_en), .rd_data_l(rd_data_l),
        .rd_data_r(rd_data_r), .flag_empty(flag_empty), .flag_mid(flag_mid),
        .flag_full(flag_full), .play_start(play_start), .running(running)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
                summary();
            end
        end
    end

    task automatic chk_flags(string req);
        int c;
        @(negedge clk); #1;
        c = (m_stereo && ch_sel) ? q_r.size() : q_l.size();
        chk({req, " empty"}, int'(flag_empty), int'((c == 0) ^ m_inv[0]));
        chk({req, " mid"},   int'(flag_mid),   int'((c > m_cap / 2) ^ m_inv[1]));
        chk({req, " full"},  int'(flag_full),  int'((c == m_cap) ^ m_inv[2]));
    endtask

    task automatic do_cfg(int size, int mode, logic [2:0] inv);
        @(negedge clk);
        cfg_load = 1; cfg_size = 2'(size); cfg_mode = 2'(mode); cfg_inv = inv;
        @(posedge clk); #1;
        cfg_load = 0;
        m_cap = (size == 0) ? 64 : (size == 1) ? 128 : 256;
        m_stereo = (mode == 2);
        m_inv = inv;
        m_run = 0;
        q_l.delete(); q_r.delete();
    endtask

    task automatic do_wr(bit wide, bit right, logic [15:0] d, string req);
        int k, sz;
        bit to_r, exp_ok;
        @(negedge clk);
        wr_en = 1; wr_wide = wide; wr_right = right; wr_data = d;
        #1;
        k = wide ? 4 : 2;
        to_r = m_stereo && right;
        sz = to_r ? q_r.size() : q_l.size();
        exp_ok = (m_cap - sz) >= k;
        chk({req, " wr_ok"}, int'(wr_ok), int'(exp_ok));
        if (exp_ok) begin
            for (int i = 0; i < k; i++) begin
                if (to_r) q_r.push_back(d[4*i +: 4]);
                else      q_l.push_back(d[4*i +: 4]);
            end
        end
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic do_rd(string req);
        @(negedge clk);
        rd_en = 1;
        #1;
        chk({req, " rd_l"}, int'(rd_data_l), (q_l.size() != 0) ? int'(q_l[0]) : 0);
        chk({req, " rd_r"}, int'(rd_data_r), (m_stereo && q_r.size() != 0) ? int'(q_r[0]) : 0);
        if (m_run) begin
            if (q_l.size() != 0) void'(q_l.pop_front());
            if (m_stereo && q_r.size() != 0) void'(q_r.pop_front());
        end
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(posedge clk); #1; start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1;
        @(posedge clk); #1; stop = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11: reset state
        chk_flags("R11 reset");
        chk("R11 reset running", int'(running), 0);
        chk("R11 reset pulse", int'(play_start), 0);
        chk("R11 reset rd", int'(rd_data_l), 0);

        // R1 R4 R5 R6 R3: fill every capacity byte by byte
        for (int s = 0; s < 3; s++) begin
            do_cfg(s, 1, 3'b000);
            chk_flags("R1 empty start");
            while (q_l.size() < m_cap) begin
                do_wr(0, 0, 16'(q_l.size() * 7 + s), "R1 fill");
                chk_flags("R4 R5 R6 sweep");
            end
            chk("R1 capacity", q_l.size(), m_cap);
            do_wr(0, 0, 16'h00AA, "R3 full narrow refused");
            do_wr(1, 0, 16'h1234, "R3 full wide refused");
            chk_flags("R3 after refused");
        end
        // R1: size code 3 behaves as 256
        do_cfg(3, 1, 3'b000);
        for (int w = 0; w < 64; w++) do_wr(1, 0, 16'(w), "R1 size3 fill");
        chk_flags("R1 size3 full");
        do_wr(0, 0, 16'h0011, "R1 size3 refused");

        // R10 R2 R9: mono playback sequence
        do_cfg(0, 1, 3'b000);
        pulse_start();
        chk("R10 armed not running", int'(running), 0);
        for (int w = 0; w < 8; w++) do_wr(1, 0, 16'hA000 ^ 16'(w * 16'h1357), "R2 load");
        @(negedge clk);
        chk("R10 half not over", int'(running), 0);
        do_rd("R10 read ignored armed");
        chk("R10 no pop while armed", q_l.size(), 32);
        do_wr(1, 0, 16'hBEEF, "R10 crossing write");
        @(negedge clk);
        chk("R10 still armed", int'(running), 0);
        chk("R10 no early pulse", int'(play_start), 0);
        @(posedge clk); #1;
        chk("R10 running", int'(running), 1);
        chk("R10 pulse", int'(play_start), 1);
        @(posedge clk); #1;
        chk("R10 pulse one cycle", int'(play_start), 0);
        m_run = 1;
        while (q_l.size() != 0) do_rd("R2 drain order");
        chk_flags("R9 drained");
        do_rd("R9 empty read zero");
        do_rd("R9 empty read again");
        do_wr(0, 0, 16'h005C, "R9 refill");
        do_rd("R9 pointer unmoved");

        // R7: every polarity at empty, over-half and full
        for (int v = 0; v < 8; v++) begin
            do_cfg(0, 1, 3'(v));
            chk_flags("R7 empty");
            for (int w = 0; w < 9; w++) do_wr(1, 0, 16'(w), "R7 fill");
            chk_flags("R7 mid");
            for (int w = 0; w < 7; w++) do_wr(1, 0, 16'(w), "R7 fill");
            chk_flags("R7 full");
        end

        // R8: stereo routing
        do_cfg(0, 2, 3'b000);
        for (int w = 0; w < 9; w++) do_wr(1, 1, 16'h7000 + 16'(w), "R8 right load");
        do_wr(0, 0, 16'h0021, "R8 left load");
        ch_sel = 0; chk_flags("R8 left view");
        ch_sel = 1; chk_flags("R8 right view");
        pulse_start();
        repeat (3) @(posedge clk);
        #1 chk("R10 stereo waits for left", int'(running), 0);
        for (int w = 0; w < 8; w++) do_wr(1, 0, 16'h4400 + 16'(w), "R10 left load");
        @(posedge clk); #1;
        chk("R10 stereo running", int'(running), 1);
        m_run = 1;
        for (int r = 0; r < 5; r++) do_rd("R8 stereo read");
        ch_sel = 0; chk_flags("R8 left after reads");
        ch_sel = 1; chk_flags("R8 right after reads");

        // R12: stop keeps data and ignores reads
        pulse_stop();
        m_run = 0;
        chk("R12 stopped", int'(running), 0);
        do_rd("R12 read ignored");
        do_rd("R12 read ignored again");

        // R8: mono ignores right select and right write
        do_cfg(0, 1, 3'b000);
        do_wr(1, 1, 16'h9876, "R8 mono write left");
        ch_sel = 1; chk_flags("R8 mono ch_sel ignored");
        chk("R8 mono rd_r zero", int'(rd_data_r), 0);
        chk("R8 mono rd_l head", int'(rd_data_l), 6);
        ch_sel = 0;

        // R10: record mode starts without pulse
        do_cfg(0, 0, 3'b000);
        pulse_start();
        chk("R10 record running", int'(running), 1);
        chk("R10 record no pulse", int'(play_start), 0);
        m_run = 1;
        do_wr(0, 0, 16'h00C3, "R10 record write");
        do_rd("R10 record read");
        do_rd("R10 record read 2");
        chk_flags("R10 record drained");

        // R11: config load mid-fill clears everything
        for (int w = 0; w < 10; w++) do_wr(1, 0, 16'(w + 1), "R11 fill");
        do_cfg(0, 1, 3'b000);
        chk_flags("R11 cleared");
        chk("R11 cleared running", int'(running), 0);
        chk("R11 cleared rd", int'(rd_data_l), 0);

        summary();
    end
endmodule